// File: doc/BRIEF.md
# Two-Packet Endpoint Buffer with Replay

This block is a byte-wide buffer for a single USB endpoint. It works on whole packets rather than a loose byte stream. A producer writes bytes and closes each packet with a commit. A consumer reads the oldest committed packet byte by byte. Up to two committed packets can wait at once, and each can have a different length, so one packet can be filled while the previous one drains.

Either side can return to the start of its current packet. On a transmit endpoint, the consumer replays a packet whose handshake failed by rewinding its read offset, and the packet's storage stays in place until the consumer releases it. On a receive endpoint, the producer drops a corrupted packet by rewinding its write pointer to where that packet began, and then takes the retry.

The byte store holds 2048 locations and is addressed by an 11-bit pointer. A small two-entry queue records the byte count of each committed packet.

Top module: `dual_set_fifo`

## Requirements
- R1: A cycle with `rst_n` low at a rising edge empties the buffer, so that afterwards `rd_empty`=1, `wr_full`=0 and `wr_overflow`=0.
- R2: Bytes written without a commit stay invisible to the reader, and `rd_empty` stays 1. `rd_empty` drops at the clock edge that accepts the commit.
- R3: Bytes of a packet are read in the order they were written. `rd_last`=1 while the final byte of the packet is presented. Once every byte has been popped, `rd_drained`=1 and `rd_last`=0.
- R4: Two committed packets can be held at once. `wr_full`=1 whenever two packets are committed and not yet released.
- R5: `wr_full`=1 when all 2048 byte locations are occupied by unreleased bytes, whether committed or not, and `wr_full`=0 while at least one location is free.
- R6: A write strobe while `wr_full`=1, or a bare commit while two packets are queued, is ignored: nothing is stored and no packet is closed. It also sets `wr_overflow`, which stays 1 until reset.
- R7: A commit with no bytes written since the previous commit queues a zero-length packet. For that packet `rd_empty`=0, `rd_drained`=1 and `rd_last`=0.
- R8: `rd_rewind` while a packet is available moves the read position back to the packet's first byte, and the packet stays queued for replay.
- R9: `wr_rewind` discards the uncommitted bytes and moves the write pointer back to the start of the open packet. It takes priority over a write or commit in the same cycle.
- R10: `rd_ack` while a packet is available frees that packet's storage and presents the first byte of the next committed packet. It takes priority over `rd_rewind` and `rd_en`.
- R11: A rewind on one side does not change the other side's position or the number of committed packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | With `wr_valid`: this byte closes the packet |
| wr_commit | input | 1 | Close the open packet without writing a byte |
| wr_rewind | input | 1 | Discard the open packet's bytes |
| wr_full | output | 1 | Two packets queued or storage exhausted |
| wr_overflow | output | 1 | Sticky: a write or commit was rejected |
| rd_en | input | 1 | Advance to the next byte of the current packet |
| rd_data | output | 8 | Byte at the current read position |
| rd_last | output | 1 | `rd_data` is the final byte of the packet |
| rd_drained | output | 1 | Every byte of the current packet has been popped |
| rd_empty | output | 1 | No committed packet is available |
| rd_ack | input | 1 | Release the current packet |
| rd_rewind | input | 1 | Replay the current packet from its first byte |

## Verification
Every flag and pointer changes at the rising edge that accepts a command. So `wr_full`, `wr_overflow`, `rd_empty`, `rd_last` and `rd_drained` are due one edge after the stimulus is driven. `rd_data` is an unregistered read of the store at the current read position, so after a pop, ack or rewind it shows the new byte once that same edge has passed. The bench drives every input just after a falling edge, holds it across exactly one rising edge, and compares outputs at the next falling edge, so each result is sampled in the first cycle it is due.

// File: rtl/dsf_pkg.sv
// Package: action encodings shared by the write-side and read-side controllers.
// Assumes nothing beyond being compiled before the modules that import it.
package dsf_pkg;

    // What the write side does at the next clock edge.
    typedef enum logic [2:0] {
        WA_IDLE,
        WA_REWIND,
        WA_PUSH,
        WA_PUSH_CLOSE,
        WA_CLOSE,
        WA_REJECT
    } wr_act_e;

    // What the read side does at the next clock edge.
    typedef enum logic [1:0] {
        RA_HOLD,
        RA_RELEASE,
        RA_REPLAY,
        RA_STEP
    } rd_act_e;

endpackage

// File: rtl/dsf_byte_ram.sv
// Module: byte store with one write port and one unregistered read port.
// Assumes the controllers never write and read-release the same location at once.
module dsf_byte_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte when the write side accepts it.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dsf_len_queue.sv
// Module: two-entry queue holding the byte count of each committed packet.
// Assumes push is never requested while two entries are already held.
module dsf_len_queue #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop,
    output logic [1:0]       count,
    output logic [LEN_W-1:0] head_len
);
    logic [LEN_W-1:0] tail_len;

    // Update the head/tail slots and the entry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= 2'd0;
            head_len <= '0;
            tail_len <= '0;
        end else begin
            if (pop && push) begin
                if (count == 2'd1) head_len <= push_len;
                else begin
                    head_len <= tail_len;
                    tail_len <= push_len;
                end
            end else if (pop) begin
                head_len <= tail_len;
                count    <= count - 2'd1;
            end else if (push) begin
                if (count == 2'd0) head_len <= push_len;
                else               tail_len <= push_len;
                count <= count + 2'd1;
            end
        end
    end
endmodule

// File: rtl/dsf_write_side.sv
// Module: producer control - write pointer, open-packet base, full and overflow.
// Assumes rd_base is the start of the oldest unreleased packet.
module dsf_write_side
    import dsf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_last,
    input  logic              wr_commit,
    input  logic              wr_rewind,
    input  logic              sets_full,
    input  logic [ADDR_W:0]   rd_base,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              q_push,
    output logic [ADDR_W:0]   q_len,
    output logic              wr_full,
    output logic              wr_overflow
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wr_ptr, wr_base, used;
    wr_act_e          act;

    assign used    = wr_ptr - rd_base;
    assign wr_full = sets_full | used[ADDR_W];

    // Decide this cycle's write action; rewind outranks everything.
    always_comb begin
        if (wr_rewind)      act = WA_REWIND;
        else if (wr_valid)  act = wr_full ? WA_REJECT : (wr_last ? WA_PUSH_CLOSE : WA_PUSH);
        else if (wr_commit) act = sets_full ? WA_REJECT : WA_CLOSE;
        else                act = WA_IDLE;
    end

    assign mem_we    = (act == WA_PUSH) || (act == WA_PUSH_CLOSE);
    assign mem_waddr = wr_ptr[ADDR_W-1:0];
    assign q_push    = (act == WA_PUSH_CLOSE) || (act == WA_CLOSE);
    assign q_len     = (wr_ptr - wr_base) + ((act == WA_PUSH_CLOSE) ? PTR_W'(1) : PTR_W'(0));

    // Advance pointers, close packets and record rejections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr      <= '0;
            wr_base     <= '0;
            wr_overflow <= 1'b0;
        end else begin
            case (act)
                WA_REWIND:     wr_ptr <= wr_base;
                WA_PUSH:       wr_ptr <= wr_ptr + PTR_W'(1);
                WA_PUSH_CLOSE: begin
                    wr_ptr  <= wr_ptr + PTR_W'(1);
                    wr_base <= wr_ptr + PTR_W'(1);
                end
                WA_CLOSE:      wr_base <= wr_ptr;
                WA_REJECT:     wr_overflow <= 1'b1;
                default:       ;
            endcase
        end
    end
endmodule

// File: rtl/dsf_read_side.sv
// Module: consumer control - packet base, offset within packet, status flags.
// Assumes head_len is the length of the oldest committed packet when count > 0.
module dsf_read_side
    import dsf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_ack,
    input  logic              rd_rewind,
    input  logic [1:0]        set_count,
    input  logic [ADDR_W:0]   head_len,
    output logic              q_pop,
    output logic [ADDR_W:0]   rd_base,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              rd_empty,
    output logic              rd_last,
    output logic              rd_drained
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] rd_off, remain, rd_ptr;
    rd_act_e          act;

    assign rd_empty = (set_count == 2'd0);
    assign remain   = head_len - rd_off;
    assign rd_ptr   = rd_base + rd_off;

    // Decide this cycle's read action; release outranks replay and step.
    always_comb begin
        if (rd_empty)                           act = RA_HOLD;
        else if (rd_ack)                        act = RA_RELEASE;
        else if (rd_rewind)                     act = RA_REPLAY;
        else if (rd_en && (remain != '0))       act = RA_STEP;
        else                                    act = RA_HOLD;
    end

    assign q_pop      = (act == RA_RELEASE);
    assign mem_raddr  = rd_ptr[ADDR_W-1:0];
    assign rd_last    = !rd_empty && (remain == PTR_W'(1));
    assign rd_drained = !rd_empty && (remain == '0);

    // Move the packet base and in-packet offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_base <= '0;
            rd_off  <= '0;
        end else begin
            case (act)
                RA_RELEASE: begin
                    rd_base <= rd_base + head_len;
                    rd_off  <= '0;
                end
                RA_REPLAY: rd_off <= '0;
                RA_STEP:   rd_off <= rd_off + PTR_W'(1);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/dual_set_fifo.sv
// Module: two-packet endpoint buffer with replay on both sides.
// Assumes one clock domain; the storage holds 2**ADDR_W bytes.
module dual_set_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              wr_commit,
    input  logic              wr_rewind,
    output logic              wr_full,
    output logic              wr_overflow,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              rd_drained,
    output logic              rd_empty,
    input  logic              rd_ack,
    input  logic              rd_rewind
);
    localparam int LEN_W = ADDR_W + 1;

    logic              mem_we, q_push, q_pop;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [LEN_W-1:0]  q_len, head_len, rd_base;
    logic [1:0]        set_count;

    dsf_byte_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(rd_data)
    );

    dsf_len_queue #(.LEN_W(LEN_W)) u_q (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_len(q_len),
        .pop(q_pop), .count(set_count), .head_len(head_len)
    );

    dsf_write_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
        .wr_commit(wr_commit), .wr_rewind(wr_rewind),
        .sets_full(set_count == 2'd2), .rd_base(rd_base),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .q_push(q_push), .q_len(q_len),
        .wr_full(wr_full), .wr_overflow(wr_overflow)
    );

    dsf_read_side #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ack(rd_ack),
        .rd_rewind(rd_rewind), .set_count(set_count), .head_len(head_len),
        .q_pop(q_pop), .rd_base(rd_base), .mem_raddr(mem_raddr),
        .rd_empty(rd_empty), .rd_last(rd_last), .rd_drained(rd_drained)
    );
endmodule

// File: rtl/dsf_checker.sv
// Module: protocol properties of the two-packet buffer, bound to its top.
// Assumes the top exposes set_count and q_push as internal nets.
module dsf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       wr_rewind,
    input logic       wr_full,
    input logic       wr_overflow,
    input logic       rd_ack,
    input logic       rd_rewind,
    input logic       rd_empty,
    input logic       rd_last,
    input logic       rd_drained,
    input logic [1:0] set_count,
    input logic       q_push
);
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_empty && !wr_full && !wr_overflow));

    a_r4_two_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (set_count == 2'd2) |-> wr_full);

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overflow |=> wr_overflow);

    a_r6_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_full && !wr_rewind) |=> wr_overflow);

    a_r9_rewind_no_close: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rewind |-> !q_push);

    a_r11_rd_rewind_keeps_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rewind && !rd_ack && !q_push) |=> (set_count == $past(set_count)));

    a_r3_last_before_drained: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_last && rd_drained));

    a_r2_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty |-> (!rd_last && !rd_drained));
endmodule

bind dual_set_fifo dsf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_rewind(wr_rewind),
    .wr_full(wr_full), .wr_overflow(wr_overflow), .rd_ack(rd_ack),
    .rd_rewind(rd_rewind), .rd_empty(rd_empty), .rd_last(rd_last),
    .rd_drained(rd_drained), .set_count(set_count), .q_push(q_push)
);

// File: tb/tb_dual_set_fifo.sv
module tb_dual_set_fifo;
    localparam int DEPTH = 2048;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 0, wr_last = 0, wr_commit = 0, wr_rewind = 0;
    logic rd_en = 0, rd_ack = 0, rd_rewind = 0;
    logic [7:0] wr_data = '0;
    logic wr_full, wr_overflow, rd_last, rd_drained, rd_empty;
    logic [7:0] rd_data;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_set_fifo dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_last(wr_last), .wr_commit(wr_commit), .wr_rewind(wr_rewind),
        .wr_full(wr_full), .wr_overflow(wr_overflow), .rd_en(rd_en),
        .rd_data(rd_data), .rd_last(rd_last), .rd_drained(rd_drained),
        .rd_empty(rd_empty), .rd_ack(rd_ack), .rd_rewind(rd_rewind)
    );

    function automatic logic [7:0] dbyte(input int id, input int idx);
        return 8'((id * 37 + idx * 11 + 5) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    task automatic step();
        @(negedge clk);
    endtask
    task automatic put(input logic [7:0] d, input bit last);
        wr_valid = 1; wr_data = d; wr_last = last; step(); wr_valid = 0; wr_last = 0;
    endtask
    task automatic commit();  wr_commit = 1; step(); wr_commit = 0; endtask
    task automatic wrew();    wr_rewind = 1; step(); wr_rewind = 0; endtask
    task automatic pop();     rd_en = 1;     step(); rd_en = 0;     endtask
    task automatic ack();     rd_ack = 1;    step(); rd_ack = 0;    endtask
    task automatic rrew();    rd_rewind = 1; step(); rd_rewind = 0; endtask
    task automatic do_reset(); rst_n = 0; step(); rst_n = 1; endtask

    // Read a whole packet and check data, end marker and drained flag.
    task automatic read_set(input int id, input int n, input string tag);
        int errs = 0, last_errs = 0;
        for (int i = 0; i < n; i++) begin
            if (rd_data != dbyte(id, i)) errs++;
            if (rd_last != (i == n - 1)) last_errs++;
            pop();
        end
        chk({tag, " data R3"}, errs, 0);
        chk({tag, " last R3"}, last_errs, 0);
        chk({tag, " drained R3"}, int'(rd_drained), 1);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);
        step(); step();
        rst_n = 1;
        chk("R1 empty", int'(rd_empty), 1);
        chk("R1 full", int'(wr_full), 0);
        chk("R1 overflow", int'(wr_overflow), 0);

        // Packet 1 without commit stays hidden
        for (int i = 0; i < 3; i++) put(dbyte(1, i), 0);
        chk("R2 hidden", int'(rd_empty), 1);
        commit();
        chk("R2 visible", int'(rd_empty), 0);

        // Packet 2 closed by end marker: two queued
        for (int i = 0; i < 5; i++) put(dbyte(2, i), i == 4);
        chk("R4 full two sets", int'(wr_full), 1);
        put(8'hEE, 0);
        chk("R6 overflow set", int'(wr_overflow), 1);
        wr_commit = 1; step(); wr_commit = 0;

        // Read rewind replays packet 1
        pop(); pop();
        chk("R8 mid data", int'(rd_data), int'(dbyte(1, 2)));
        rrew();
        chk("R8 replay first", int'(rd_data), int'(dbyte(1, 0)));
        chk("R11 rd rewind keeps full", int'(wr_full), 1);
        read_set(1, 3, "pkt1");
        ack();
        chk("R10 next packet", int'(rd_data), int'(dbyte(2, 0)));
        chk("R10 one set left", int'(wr_full), 0);

        // Write rewind discards open packet
        pop();
        for (int i = 0; i < 4; i++) put(dbyte(3, i), 0);
        wrew();
        chk("R11 wr rewind keeps read pos", int'(rd_data), int'(dbyte(2, 1)));
        chk("R11 wr rewind keeps sets", int'(rd_empty), 0);
        wr_valid = 1; wr_data = 8'h55; wr_rewind = 1; step();
        wr_valid = 0; wr_rewind = 0;
        for (int i = 0; i < 2; i++) put(dbyte(4, i), i == 1);
        rrew();
        read_set(2, 5, "pkt2 R6 no extra byte");
        ack();
        read_set(4, 2, "pkt4 R9");
        ack();
        chk("R10 empty after acks", int'(rd_empty), 1);
        chk("R6 sticky", int'(wr_overflow), 1);

        // Zero-length packet
        commit();
        chk("R7 not empty", int'(rd_empty), 0);
        chk("R7 drained", int'(rd_drained), 1);
        chk("R7 no last", int'(rd_last), 0);
        ack();
        chk("R7 released", int'(rd_empty), 1);

        // Storage exhaustion
        do_reset();
        chk("R1 overflow cleared", int'(wr_overflow), 0);
        chk("R1 empty again", int'(rd_empty), 1);
        for (int i = 0; i < DEPTH - 1; i++) put(dbyte(7, i), 0);
        chk("R5 one free", int'(wr_full), 0);
        put(dbyte(7, DEPTH - 1), 0);
        chk("R5 full storage", int'(wr_full), 1);
        put(8'hAA, 1);
        chk("R6 storage reject", int'(wr_overflow), 1);
        chk("R6 no close on reject", int'(rd_empty), 1);
        commit();
        chk("R5 commit allowed", int'(rd_empty), 0);
        read_set(7, DEPTH, "big");
        ack();
        chk("R5 freed", int'(wr_full), 0);

        // Random packets
        do_reset();
        for (int p = 0; p < 40; p++) begin
            int id = 100 + p;
            int len = $urandom_range(0, 24);
            if ($urandom_range(0, 3) == 0) begin
                int k = $urandom_range(1, 5);
                for (int i = 0; i < k; i++) put(dbyte(999, i), 0);
                wrew();
            end
            for (int i = 0; i < len; i++) begin
                put(dbyte(id, i), i == len - 1);
                if ($urandom_range(0, 2) == 0) step();
            end
            if (len == 0) commit();
            if (len > 1 && $urandom_range(0, 2) == 0) begin
                int r = $urandom_range(1, len - 1);
                for (int i = 0; i < r; i++) pop();
                rrew();
            end
            read_set(id, len, "rand R8 R9");
            ack();
            chk("rand R10 empty", int'(rd_empty), 1);
        end
        chk("rand R6 no overflow", int'(wr_overflow), 0);
        summary();
    end
endmodule